// File: doc/BRIEF.md
# Accumulator and Extend-Bit Datapath

This block holds a processor's accumulator together with a one-bit extend register, and contains the adder and logic circuit that computes the accumulator's next value. The sequencer does not present an encoded opcode. It raises one strobe per operation: bitwise AND with the data operand, add with carry into the extend bit, load from the data operand, load from the 8-bit input character, complement, rotate right, rotate left, clear and increment. Two further commands act on the extend bit alone. When no strobe is raised, the accumulator keeps its value.

The accumulator and the extend bit together form a circulate-and-carry path of width W+1. An add places its carry-out in the extend bit. The two rotates move bits through the extend bit, so a bit that leaves one end of the accumulator enters the extend bit, and the old extend bit enters the other end. The block decodes the strobe vector into an enumerated operation (`OP_HOLD`, `OP_AND`, `OP_ADD`, `OP_LDD`, `OP_LDI`, `OP_CPL`, `OP_ROR`, `OP_ROL`, `OP_CLR`, `OP_INC`, `OP_BAD`). `OP_BAD` covers any pattern with more than one strobe. Each accepted operation moves the register pair from its current value to its next value on one clock edge. The status outputs (sign, zero and extend-zero) drive the conditional-skip logic elsewhere in the core.

Top module: `acx_accum`

## Requirements
- R1: While `rst_n` is low, and after it rises, the accumulator reads 0 and the extend bit reads 0 until the first accepted operation.
- R2: Strobe bit 0 alone sets the accumulator to (accumulator AND `dr_in`) on the next edge.
- R3: Strobe bit 1 alone sets {extend, accumulator} to the W+1-bit sum of the accumulator and `dr_in`, so the carry-out lands in the extend bit.
- R4: Strobe bit 2 alone loads all W bits of `dr_in` into the accumulator.
- R5: Strobe bit 3 alone loads `inpr_in` into the low IW bits of the accumulator and zeroes the remaining upper bits.
- R6: Strobe bit 5 alone rotates right through the extend bit: the accumulator's top bit takes the old extend bit, and the extend bit takes the old bit 0.
- R7: Strobe bit 6 alone rotates left through the extend bit: the accumulator's bit 0 takes the old extend bit, and the extend bit takes the old top bit.
- R8: Strobe bit 4 alone complements the accumulator, bit 7 alone clears it, and bit 8 alone adds 1 to it modulo 2^W. None of these three changes the extend bit by itself.
- R9: `e_clr` zeroes the extend bit and `e_cpl` inverts it. When both are raised, the extend bit becomes 1 (clear, then complement). When strobe bit 1, 5 or 6 is raised in the same cycle, that operation's value for the extend bit wins and the commands are ignored.
- R10: `ac_neg` equals the accumulator's top bit and `ac_pos` equals its inverse. `ac_zero` is 1 exactly when the accumulator is 0, and `e_zero` is 1 exactly when the extend bit is 0.
- R11: `op_err` is 1 in the same cycle exactly when two or more strobe bits are raised. In that cycle the accumulator and the extend bit both keep their values, including against `e_clr` and `e_cpl`.
- R12: With no strobe raised, the accumulator keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_strb | input | 9 | One-hot operation strobes (bit map in R2 to R8) |
| e_clr | input | 1 | Clear the extend bit |
| e_cpl | input | 1 | Complement the extend bit |
| dr_in | input | W | Data operand |
| inpr_in | input | IW | Input character |
| ac_out | output | W | Accumulator value to the bus |
| e_out | output | 1 | Extend bit |
| ac_pos | output | 1 | Accumulator top bit is 0 |
| ac_neg | output | 1 | Accumulator top bit is 1 |
| ac_zero | output | 1 | Accumulator is zero |
| e_zero | output | 1 | Extend bit is zero |
| op_err | output | 1 | More than one strobe raised this cycle |

## Verification
The bench builds the block with W = 16 and IW = 8. At that size a short directed run can reach the carry out of 0xFFFF + 1 and the wrap of increment at 0xFFFF. It can also bring a bit all the way round the 17-bit rotate loop. With an 8-bit character and a 16-bit accumulator, a wrong clear of the upper byte on a character load shows up directly. Random single strobes, idle cycles and two-strobe collisions, each mixed with random extend commands, cover every decoded operation and the precedence between ALU writes to the extend bit and the separate extend commands.

// File: rtl/acx_pkg.sv
`timescale 1ns/1ps
package acx_pkg;
    // strobe positions; the sequencer relies on this map
    localparam int S_AND = 0;
    localparam int S_ADD = 1;
    localparam int S_LDD = 2;
    localparam int S_LDI = 3;
    localparam int S_CPL = 4;
    localparam int S_ROR = 5;
    localparam int S_ROL = 6;
    localparam int S_CLR = 7;
    localparam int S_INC = 8;
    localparam int OP_N  = 9;

    typedef enum logic [3:0] {
        OP_HOLD,
        OP_AND,
        OP_ADD,
        OP_LDD,
        OP_LDI,
        OP_CPL,
        OP_ROR,
        OP_ROL,
        OP_CLR,
        OP_INC,
        OP_BAD
    } acx_op_e;
endpackage

// File: rtl/acx_decode.sv
`timescale 1ns/1ps
module acx_decode
    import acx_pkg::*;
(
    input  logic [OP_N-1:0] strb,
    output acx_op_e         op,
    output logic            multi
);
    localparam logic [OP_N-1:0] ONE = OP_N'(1);

    always_comb begin
        multi = ($countones(strb) > 1);
        op    = OP_BAD;
        unique case (strb)
            '0:            op = OP_HOLD;
            (ONE << S_AND): op = OP_AND;
            (ONE << S_ADD): op = OP_ADD;
            (ONE << S_LDD): op = OP_LDD;
            (ONE << S_LDI): op = OP_LDI;
            (ONE << S_CPL): op = OP_CPL;
            (ONE << S_ROR): op = OP_ROR;
            (ONE << S_ROL): op = OP_ROL;
            (ONE << S_CLR): op = OP_CLR;
            (ONE << S_INC): op = OP_INC;
            default:        op = OP_BAD;
        endcase
    end
endmodule

// File: rtl/acx_alu.sv
`timescale 1ns/1ps
module acx_alu
    import acx_pkg::*;
#(
    parameter int W  = 16,
    parameter int IW = 8
) (
    input  acx_op_e        op,
    input  logic [W-1:0]   ac,
    input  logic           e,
    input  logic [W-1:0]   dr,
    input  logic [IW-1:0]  inp,
    input  logic           e_clr,
    input  logic           e_cpl,
    output logic [W-1:0]   ac_nx,
    output logic           e_nx
);
    localparam int PAD = W - IW;

    logic [W:0] sum;
    logic       e_cmd;

    always_comb begin
        sum   = {1'b0, ac} + {1'b0, dr};
        // clear is applied before complement
        e_cmd = e_clr ? 1'b0 : e;
        e_cmd = e_cpl ? ~e_cmd : e_cmd;
    end

    always_comb begin
        ac_nx = ac;
        e_nx  = e_cmd;
        unique case (op)
            OP_HOLD: ac_nx = ac;
            OP_AND:  ac_nx = ac & dr;
            OP_ADD:  {e_nx, ac_nx} = sum;
            OP_LDD:  ac_nx = dr;
            OP_LDI:  ac_nx = {{PAD{1'b0}}, inp};
            OP_CPL:  ac_nx = ~ac;
            OP_ROR: begin
                ac_nx = {e, ac[W-1:1]};
                e_nx  = ac[0];
            end
            OP_ROL: begin
                ac_nx = {ac[W-2:0], e};
                e_nx  = ac[W-1];
            end
            OP_CLR:  ac_nx = '0;
            OP_INC:  ac_nx = ac + W'(1);
            OP_BAD: begin
                ac_nx = ac;
                e_nx  = e;
            end
            default: begin
                ac_nx = ac;
                e_nx  = e;
            end
        endcase
    end
endmodule

// File: rtl/acx_status.sv
`timescale 1ns/1ps
module acx_status #(
    parameter int W = 16
) (
    input  logic [W-1:0] ac,
    input  logic         e,
    output logic         pos,
    output logic         neg,
    output logic         zero,
    output logic         ezero
);
    always_comb begin
        neg   = ac[W-1];
        pos   = ~ac[W-1];
        zero  = ~|ac;
        ezero = ~e;
    end
endmodule

// File: rtl/acx_accum.sv
`timescale 1ns/1ps
module acx_accum
    import acx_pkg::*;
#(
    parameter int W  = 16,
    parameter int IW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [8:0]      op_strb,
    input  logic            e_clr,
    input  logic            e_cpl,
    input  logic [W-1:0]    dr_in,
    input  logic [IW-1:0]   inpr_in,
    output logic [W-1:0]    ac_out,
    output logic            e_out,
    output logic            ac_pos,
    output logic            ac_neg,
    output logic            ac_zero,
    output logic            e_zero,
    output logic            op_err
);
    acx_op_e      op;
    logic         multi;
    logic [W-1:0] ac_q, ac_d;
    logic         e_q, e_d;

    acx_decode u_dec (
        .strb  (op_strb),
        .op    (op),
        .multi (multi)
    );

    acx_alu #(.W(W), .IW(IW)) u_alu (
        .op    (op),
        .ac    (ac_q),
        .e     (e_q),
        .dr    (dr_in),
        .inp   (inpr_in),
        .e_clr (e_clr),
        .e_cpl (e_cpl),
        .ac_nx (ac_d),
        .e_nx  (e_d)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q <= '0;
            e_q  <= 1'b0;
        end else begin
            ac_q <= ac_d;
            e_q  <= e_d;
        end
    end

    acx_status #(.W(W)) u_st (
        .ac    (ac_q),
        .e     (e_q),
        .pos   (ac_pos),
        .neg   (ac_neg),
        .zero  (ac_zero),
        .ezero (e_zero)
    );

    // outputs
    always_comb begin
        ac_out = ac_q;
        e_out  = e_q;
        op_err = multi;
    end
endmodule

// File: rtl/acx_accum_chk.sv
`timescale 1ns/1ps
module acx_accum_chk #(
    parameter int W  = 16,
    parameter int IW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [8:0]      op_strb,
    input logic            e_clr,
    input logic            e_cpl,
    input logic [W-1:0]    dr_in,
    input logic [IW-1:0]   inpr_in,
    input logic [W-1:0]    ac_out,
    input logic            e_out,
    input logic            ac_pos,
    input logic            ac_neg,
    input logic            ac_zero,
    input logic            e_zero,
    input logic            op_err
);
    // R3
    add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strb == 9'h002) |=>
        ({e_out, ac_out} == ({1'b0, $past(ac_out)} + {1'b0, $past(dr_in)})));

    // R6
    ror_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strb == 9'h020) |=>
        (ac_out == {$past(e_out), $past(ac_out[W-1:1])}) && (e_out == $past(ac_out[0])));

    // R5
    char_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strb == 9'h008) |=> (ac_out[W-1:IW] == '0) && (ac_out[IW-1:0] == $past(inpr_in)));

    // R8
    inc_keeps_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strb == 9'h100 && !e_clr && !e_cpl) |=> $stable(e_out));

    // R11
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |=> ($stable(ac_out) && $stable(e_out)));

    // R11
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_err == ($countones(op_strb) > 1));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strb == 9'h000) |=> $stable(ac_out));
endmodule

bind acx_accum acx_accum_chk #(.W(W), .IW(IW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_strb (op_strb),
    .e_clr   (e_clr),
    .e_cpl   (e_cpl),
    .dr_in   (dr_in),
    .inpr_in (inpr_in),
    .ac_out  (ac_out),
    .e_out   (e_out),
    .ac_pos  (ac_pos),
    .ac_neg  (ac_neg),
    .ac_zero (ac_zero),
    .e_zero  (e_zero),
    .op_err  (op_err)
);

// File: tb/acx_accum_tb.sv
`timescale 1ns/1ps
module acx_accum_tb;
    localparam int W  = 16;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [8:0]    op_strb = '0;
    logic          e_clr = 1'b0, e_cpl = 1'b0;
    logic [W-1:0]  dr_in = '0;
    logic [IW-1:0] inpr_in = '0;
    logic [W-1:0]  ac_out;
    logic          e_out, ac_pos, ac_neg, ac_zero, e_zero, op_err;

    int n_chk = 0, n_bad = 0;
    logic [W-1:0] m_ac = '0;
    logic         m_e  = 1'b0;
    bit           done = 0;

    always #10 clk = ~clk;

    acx_accum #(.W(W), .IW(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_strb(op_strb), .e_clr(e_clr), .e_cpl(e_cpl),
        .dr_in(dr_in), .inpr_in(inpr_in), .ac_out(ac_out), .e_out(e_out),
        .ac_pos(ac_pos), .ac_neg(ac_neg), .ac_zero(ac_zero), .e_zero(e_zero),
        .op_err(op_err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic string tag_of(input logic [8:0] s, input logic c, input logic p);
        case (s)
            9'h000:  return (c || p) ? "R9 extend cmd" : "R12 idle";
            9'h001:  return "R2 and";
            9'h002:  return "R3 add";
            9'h004:  return "R4 load dr";
            9'h008:  return "R5 load char";
            9'h010:  return "R8 complement";
            9'h020:  return "R6 rotate right";
            9'h040:  return "R7 rotate left";
            9'h080:  return "R8 clear";
            9'h100:  return "R8 increment";
            default: return "R11 collision";
        endcase
    endfunction

    function automatic logic [W:0] model(input logic [8:0] s, input logic c, input logic p,
                                         input logic [W-1:0] d, input logic [IW-1:0] i,
                                         input logic [W-1:0] a, input logic e);
        logic ne;
        ne = e;
        if ($countones(s) > 1) return {e, a};
        if (c) ne = 1'b0;
        if (p) ne = ~ne;
        case (s)
            9'h001: return {ne, a & d};
            9'h002: return {1'b0, a} + {1'b0, d};
            9'h004: return {ne, d};
            9'h008: return {ne, 8'h00, i};
            9'h010: return {ne, ~a};
            9'h020: return {a[0], e, a[W-1:1]};
            9'h040: return {a[W-1], a[W-2:0], e};
            9'h080: return {ne, {W{1'b0}}};
            9'h100: return {ne, a + 16'd1};
            default: return {ne, a};
        endcase
    endfunction

    task automatic step(input logic [8:0] s, input logic c, input logic p,
                        input logic [W-1:0] d, input logic [IW-1:0] i);
        logic [W:0] nx;
        string tg;
        op_strb = s; e_clr = c; e_cpl = p; dr_in = d; inpr_in = i;
        #2;
        chk("R11 op_err", {31'd0, op_err}, {31'd0, ($countones(s) > 1)});
        tg = tag_of(s, c, p);
        nx = model(s, c, p, d, i, m_ac, m_e);
        @(negedge clk);
        m_ac = nx[W-1:0];
        m_e  = nx[W];
        chk({tg, " ac"}, {16'd0, ac_out}, {16'd0, m_ac});
        chk({tg, " e"}, {31'd0, e_out}, {31'd0, m_e});
        chk("R10 flags", {28'd0, ac_pos, ac_neg, ac_zero, e_zero},
            {28'd0, ~m_ac[W-1], m_ac[W-1], (m_ac == '0), ~m_e});
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog: got hang expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7301));
        dr_in = 16'hFFFF; inpr_in = 8'hFF; op_strb = 9'h004;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset ac", {16'd0, ac_out}, 32'd0);
        chk("R1 reset e", {31'd0, e_out}, 32'd0);
        op_strb = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset ac", {16'd0, ac_out}, 32'd0);

        // directed corners
        step(9'h004, 0, 0, 16'hFFFF, 8'h00);   // R4
        step(9'h002, 0, 0, 16'h0001, 8'h00);   // R3 carry: 0 + E=1
        step(9'h020, 0, 0, 16'h0000, 8'h00);   // R6
        step(9'h040, 0, 0, 16'h0000, 8'h00);   // R7
        step(9'h100, 0, 0, 16'h0000, 8'h00);   // R8
        step(9'h004, 0, 0, 16'hFFFF, 8'h00);
        step(9'h100, 0, 0, 16'h0000, 8'h00);   // R8 wrap
        step(9'h008, 0, 0, 16'hABCD, 8'h5A);   // R5
        step(9'h000, 1, 1, 16'h0000, 8'h00);   // R9 both -> 1
        step(9'h000, 1, 0, 16'h0000, 8'h00);   // R9 clear
        step(9'h000, 0, 1, 16'h0000, 8'h00);   // R9 complement
        step(9'h020, 1, 0, 16'h0000, 8'h00);   // R9 rotate wins
        step(9'h003, 1, 1, 16'h1234, 8'h00);   // R11 collision
        step(9'h180, 0, 1, 16'h0000, 8'h00);   // R11 collision
        step(9'h010, 0, 0, 16'h0000, 8'h00);   // R8 complement
        step(9'h001, 0, 0, 16'h0F0F, 8'h00);   // R2
        step(9'h080, 0, 0, 16'h0000, 8'h00);   // R8 clear
        for (int k = 0; k < 17; k++) step(9'h040, 0, 0, 16'h0000, 8'h00);

        for (int n = 0; n < 600; n++) begin
            int kind, a, b;
            logic [8:0] s;
            logic [W-1:0] d;
            kind = int'($urandom % 12);
            if (kind < 9) s = 9'(1) << kind;
            else if (kind == 9) s = '0;
            else begin
                a = int'($urandom % 9);
                b = (a + 1 + int'($urandom % 8)) % 9;
                s = (9'(1) << a) | (9'(1) << b);
            end
            d = 16'($urandom);
            if ($urandom % 8 == 0) d = 16'hFFFF;
            step(s, ($urandom % 4 == 0), ($urandom % 4 == 0), d, 8'($urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule